// File: doc/BRIEF.md
# Flag-Setting Test and Compare Unit

This unit executes the three test-class data-processing operations of a 32-bit RISC instruction word: bitwise test (AND), test-equivalence (XOR) and compare (subtract). The operand fetch stage presents the instruction word, the first operand, the already shifted second operand with its shifter carry-out, and the current condition flags. The unit decodes the word, computes an internal result that is never written back, and loads a new N, Z, C, V set into its flag register on the next clock edge.

Words that are not one of these three operations are reported on a combinational not-handled output, and the flag register keeps its value for them. A destination write-enable output tells the surrounding pipeline whether a data-processing word would write its destination register. It is always low for the test-class operations.

Top module: `flag_test_unit`

## Requirements
- R1: With `valid_i` high, a word is handled only when bits 27:26 are 00, bit 20 is 1 and bits 24:21 are 1000, 1001 or 1010. `nothandled_o` is high exactly when `valid_i` is high and the word is not handled. Opcode 1011 is not handled.
- R2: Opcode 1000 forms the internal result `op1_i AND op2_i`.
- R3: Opcode 1001 forms the internal result `op1_i XOR op2_i`.
- R4: Opcode 1010 forms the internal result `op1_i - op2_i` (modulo 2^32). For every handled word, N is bit 31 of the result and Z is 1 when the result is zero. `flags_o` is packed as {N, Z, C, V} in bits 3:0.
- R5: For opcode 1010, C is 1 when `op1_i >= op2_i` as unsigned numbers (no borrow), else 0.
- R6: For opcode 1010, V is 1 when the operand signs differ and the result sign differs from the sign of `op1_i`.
- R7: For opcodes 1000 and 1001, C takes `shcarry_i` and V takes bit 0 of `flags_i`.
- R8: `flags_o` takes the new flags at the rising clock edge on which a handled word is valid. On any other edge it keeps its value.
- R9: `rdwe_o` is high only for a valid word with bits 27:26 equal to 00 and an opcode outside 1000 to 1011. It is low for every handled word.
- R10: Bits 31:28, bit 25 and bits 19:0 of the word have no effect on the result or on the flags.
- R11: A low `rst_ni` at a rising edge clears `flags_o` to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | The instruction word and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| op1_i | input | 32 | First operand register value |
| op2_i | input | 32 | Shifted second operand |
| shcarry_i | input | 1 | Carry-out of the shifter for the second operand |
| flags_i | input | 4 | Current flags {N, Z, C, V} |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |
| nothandled_o | output | 1 | Valid word is not a test-class operation |
| rdwe_o | output | 1 | Valid data-processing word would write its destination |

## Verification
The rejection path and the flag-register hold share the same cycle: when a valid word is refused by the decoder, the same clock edge must leave the register untouched while `nothandled_o` is high. The bench provokes this by first loading a known flag pattern with a compare, then presenting an arithmetic opcode, a non-data-processing class, a cleared set-flags bit and opcode 1011, each with operands that would produce a different pattern. Each case is judged by sampling `nothandled_o` and `rdwe_o` before the edge and `flags_o` after it, against the earlier pattern.

// File: rtl/ftu_pkg.sv
package ftu_pkg;

  localparam int unsigned XW      = 32;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned OPC_LSB = 21;
  localparam int unsigned CLS_LSB = 26;
  localparam int unsigned SBIT    = 20;

  typedef enum logic [OPC_W-1:0] {
    OPC_TST = 4'b1000,
    OPC_TEQ = 4'b1001,
    OPC_CMP = 4'b1010,
    OPC_CMN = 4'b1011
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Bitwise result of the two logical tests.
  function automatic logic [XW-1:0] logic_res(input logic is_xor,
                                              input logic [XW-1:0] a,
                                              input logic [XW-1:0] b);
    return is_xor ? (a ^ b) : (a & b);
  endfunction

  // Subtraction as a + ~b + 1; the top bit is the no-borrow carry.
  function automatic logic [XW:0] sub_full(input logic [XW-1:0] a,
                                           input logic [XW-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{XW{1'b0}}, 1'b1};
  endfunction

  // Signed overflow of a - b given the difference d.
  function automatic logic sub_ovf(input logic [XW-1:0] a,
                                   input logic [XW-1:0] b,
                                   input logic [XW-1:0] d);
    return (a[XW-1] ^ b[XW-1]) & (a[XW-1] ^ d[XW-1]);
  endfunction

endpackage

// File: rtl/ftu_decode.sv
module ftu_decode
  import ftu_pkg::*;
(
  input  logic          valid_i,
  input  logic [XW-1:0] instr_i,
  output logic          handled_o,
  output logic          is_cmp_o,
  output logic          is_xor_o,
  output logic          rdwe_o,
  output logic          nothandled_o
);

  logic [1:0]       cls;
  logic [OPC_W-1:0] opc;
  logic             setf;
  logic             dp_cls;
  logic             test_grp;
  logic             known;

  assign cls    = instr_i[CLS_LSB +: 2];
  assign opc    = instr_i[OPC_LSB +: OPC_W];
  assign setf   = instr_i[SBIT];
  assign dp_cls = (cls == 2'b00);

  // Opcodes 1000..1011 never write the destination.
  assign test_grp = (opc[OPC_W-1 -: 2] == 2'b10);

  always_comb begin
    known = 1'b0;
    case (opc)
      OPC_TST, OPC_TEQ, OPC_CMP: known = 1'b1;
      default:                   known = 1'b0;
    endcase
  end

  assign handled_o    = valid_i & dp_cls & setf & known;
  assign is_cmp_o     = (opc == OPC_CMP);
  assign is_xor_o     = (opc == OPC_TEQ);
  assign rdwe_o       = valid_i & dp_cls & ~test_grp;
  assign nothandled_o = valid_i & ~handled_o;

endmodule

// File: rtl/ftu_alu.sv
module ftu_alu
  import ftu_pkg::*;
(
  input  logic          is_cmp_i,
  input  logic          is_xor_i,
  input  logic [XW-1:0] op1_i,
  input  logic [XW-1:0] op2_i,
  input  logic          shcarry_i,
  input  logic          v_in_i,
  output logic [XW-1:0] res_o,
  output flags_t        nxt_o
);

  logic [XW:0]   diff;
  logic [XW-1:0] lres;

  assign diff = sub_full(op1_i, op2_i);
  assign lres = logic_res(is_xor_i, op1_i, op2_i);

  always_comb begin
    if (is_cmp_i) begin
      res_o   = diff[XW-1:0];
      nxt_o.c = diff[XW];
      nxt_o.v = sub_ovf(op1_i, op2_i, diff[XW-1:0]);
    end else begin
      res_o   = lres;
      nxt_o.c = shcarry_i;
      nxt_o.v = v_in_i;
    end
    nxt_o.n = res_o[XW-1];
    nxt_o.z = (res_o == '0);
  end

endmodule

// File: rtl/ftu_flag_reg.sv
module ftu_flag_reg
  import ftu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/flag_test_unit.sv
module flag_test_unit
  import ftu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XW-1:0]     instr_i,
  input  logic [XW-1:0]     op1_i,
  input  logic [XW-1:0]     op2_i,
  input  logic              shcarry_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              nothandled_o,
  output logic              rdwe_o
);

  logic          dec_handled;
  logic          dec_cmp;
  logic          dec_xor;
  logic [XW-1:0] alu_res;
  flags_t        alu_nxt;
  flags_t        cur;
  flags_t        q;

  assign cur = flags_t'(flags_i);

  ftu_decode u_dec (
    .valid_i      (valid_i),
    .instr_i      (instr_i),
    .handled_o    (dec_handled),
    .is_cmp_o     (dec_cmp),
    .is_xor_o     (dec_xor),
    .rdwe_o       (rdwe_o),
    .nothandled_o (nothandled_o)
  );

  ftu_alu u_alu (
    .is_cmp_i  (dec_cmp),
    .is_xor_i  (dec_xor),
    .op1_i     (op1_i),
    .op2_i     (op2_i),
    .shcarry_i (shcarry_i),
    .v_in_i    (cur.v),
    .res_o     (alu_res),
    .nxt_o     (alu_nxt)
  );

  ftu_flag_reg u_freg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dec_handled),
    .d_i    (alu_nxt),
    .q_o    (q)
  );

  assign flags_o = q;

endmodule

// File: rtl/ftu_checker.sv
module ftu_checker
  import ftu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [XW-1:0]     op1_i,
  input logic [XW-1:0]     op2_i,
  input logic              shcarry_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              nothandled_o,
  input logic              rdwe_o,
  input logic              handled,
  input logic              is_cmp,
  input logic [XW-1:0]     res
);

  p_nothandled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nothandled_o |-> (valid_i && !handled));

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handled |=> (flags_o[2] == ($past(res) == '0)));

  p_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handled |=> (flags_o[3] == $past(res[XW-1])));

  p_cmp_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handled && is_cmp) |=> (flags_o[1] == ($past(op1_i) >= $past(op2_i))));

  p_cmp_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handled && is_cmp) |=> (flags_o[0] ==
      (($past(op1_i[XW-1]) != $past(op2_i[XW-1])) &&
       ($past(res[XW-1]) != $past(op1_i[XW-1])))));

  p_logic_cv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handled && !is_cmp) |=> ((flags_o[1] == $past(shcarry_i)) &&
                              (flags_o[0] == $past(flags_i[0]))));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !handled |=> $stable(flags_o));

  p_no_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdwe_o && handled));

  p_reset_r11: assert property (@(posedge clk_i)
    !rst_ni |=> (flags_o == '0));

endmodule

bind flag_test_unit ftu_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op1_i        (op1_i),
  .op2_i        (op2_i),
  .shcarry_i    (shcarry_i),
  .flags_i      (flags_i),
  .flags_o      (flags_o),
  .nothandled_o (nothandled_o),
  .rdwe_o       (rdwe_o),
  .handled      (dec_handled),
  .is_cmp       (dec_cmp),
  .res          (alu_res)
);

// File: tb/flag_test_unit_tb.sv
module flag_test_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] op1 = '0;
  logic [31:0] op2 = '0;
  logic        shc = 1'b0;
  logic [3:0]  fin = '0;
  logic [3:0]  fout;
  logic        nh;
  logic        we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_test_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .instr_i(instr),
    .op1_i(op1), .op2_i(op2), .shcarry_i(shc), .flags_i(fin),
    .flags_o(fout), .nothandled_o(nh), .rdwe_o(we)
  );

  // {opcode, op1, op2, shifter carry, flags in, expected flags {N,Z,C,V}}
  localparam logic [76:0] VEC [10] = '{
    {4'b1000, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1, 4'b0001, 4'b0111}, // R2 zero
    {4'b1000, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 4'b0000, 4'b1000}, // R2 neg
    {4'b1001, 32'h1234_5678, 32'h1234_5678, 1'b0, 4'b1111, 4'b0101}, // R3 equal
    {4'b1001, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'b0000, 4'b1010}, // R3 neg
    {4'b1010, 32'h0000_0005, 32'h0000_0003, 1'b0, 4'b1101, 4'b0010}, // R5 no borrow
    {4'b1010, 32'h0000_0003, 32'h0000_0005, 1'b1, 4'b0000, 4'b1000}, // R5 borrow
    {4'b1010, 32'h0000_0007, 32'h0000_0007, 1'b0, 4'b0001, 4'b0110}, // R4 equal
    {4'b1010, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'b0000, 4'b0011}, // R6 ovf
    {4'b1010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'b0000, 4'b1001}, // R6 ovf
    {4'b1010, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'b1000, 4'b0110}  // R4 zero
  };

  function automatic logic [31:0] mk(input logic [3:0] opc, input logic [1:0] cls,
                                     input logic s, input logic imm,
                                     input logic [19:0] low);
    return {4'hE, cls, imm, opc, s, low[19:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check decode outputs before the rising edge,
  // flags one step after it.
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input logic c, input logic [3:0] f,
                      input logic exp_nh, input logic exp_we, input logic [3:0] exp_f,
                      input string req);
    @(negedge clk);
    valid = v; instr = w; op1 = a; op2 = b; shc = c; fin = f;
    #1;
    check({req, " nothandled (R1)"}, {31'b0, nh}, {31'b0, exp_nh});
    check({req, " write-enable (R9)"}, {31'b0, we}, {31'b0, exp_we});
    @(posedge clk);
    #1;
    check({req, " flags"}, {28'b0, fout}, {28'b0, exp_f});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset flags", {28'b0, fout}, 32'd0);
    check("R1 idle nothandled", {31'b0, nh}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    foreach (VEC[i]) begin
      step(1'b1, mk(VEC[i][76:73], 2'b00, 1'b1, 1'b0, 20'h1_0000),
           VEC[i][72:41], VEC[i][40:9], VEC[i][8], VEC[i][7:4],
           1'b0, 1'b0, VEC[i][3:0], $sformatf("R2-table entry %0d", i));
    end

    // Load a known pattern: CMP 3-5 -> 1000
    step(1'b1, mk(4'b1010, 2'b00, 1'b1, 1'b0, 20'h0), 32'd3, 32'd5, 1'b0, 4'b0000,
         1'b0, 1'b0, 4'b1000, "R5 load");
    // Arithmetic opcode: rejected, writes Rd, flags hold (R8)
    step(1'b1, mk(4'b0100, 2'b00, 1'b1, 1'b0, 20'h0), 32'd7, 32'd7, 1'b1, 4'b0001,
         1'b1, 1'b1, 4'b1000, "R8 add rejected");
    // Other class
    step(1'b1, mk(4'b1010, 2'b01, 1'b1, 1'b0, 20'h0), 32'd7, 32'd7, 1'b1, 4'b0001,
         1'b1, 1'b0, 4'b1000, "R1 class 01");
    // Set-flags bit clear
    step(1'b1, mk(4'b1000, 2'b00, 1'b0, 1'b0, 20'h0), 32'd0, 32'd0, 1'b1, 4'b0001,
         1'b1, 1'b0, 4'b1000, "R1 S clear");
    // Opcode 1011
    step(1'b1, mk(4'b1011, 2'b00, 1'b1, 1'b0, 20'h0), 32'd0, 32'd0, 1'b1, 4'b0001,
         1'b1, 1'b0, 4'b1000, "R1 opcode 1011");
    // Valid low with a handled word: no update
    step(1'b0, mk(4'b1010, 2'b00, 1'b1, 1'b0, 20'h0), 32'd0, 32'd0, 1'b1, 4'b0001,
         1'b0, 1'b0, 4'b1000, "R8 valid low");
    // Immediate bit, Rn, Rd, operand2 field and condition bits ignored (R10)
    step(1'b1, {4'h0, 2'b00, 1'b1, 4'b1010, 1'b1, 20'hFFFFF}, 32'h8000_0000, 32'd1,
         1'b0, 4'b0000, 1'b0, 1'b0, 4'b0011, "R10 fields ignored");
    step(1'b1, {4'h5, 2'b00, 1'b1, 4'b1001, 1'b1, 20'h3C5A5}, 32'd1, 32'h8000_0000,
         1'b1, 4'b0000, 1'b0, 1'b0, 4'b1010, "R10 fields ignored teq");
    // TST keeps V from flags_i (R7)
    step(1'b1, mk(4'b1000, 2'b00, 1'b1, 1'b0, 20'h0), 32'hFF, 32'h0F, 1'b0, 4'b1111,
         1'b0, 1'b0, 4'b0001, "R7 tst keeps V");

    // Reset in mid-run (R11)
    @(negedge clk);
    valid = 1'b0;
    rst_ni = 1'b0;
    @(posedge clk);
    #1;
    check("R11 mid-run reset", {28'b0, fout}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule